// File: doc/BRIEF.md
# Longest Prefix Match CAM

This block is a small route-lookup table for 32-bit addresses. Each entry holds one stored address, one prefix length and one valid bit. A lookup key is compared with every entry in parallel. Each entry does not return a plain hit or miss. It returns how many of its leading bits agree with the key, and that count is capped at its own prefix length. Entries can therefore be loaded in any order.

A pipelined selection tree compares these match lengths in pairs. At each node the `TAKE_LEFT` or `TAKE_RIGHT` decision keeps the longer length. On equal lengths it keeps the left side, which holds the lower index. The root gives a found flag, the winning entry index and its match length.

A single write port loads or clears one entry per cycle. A new lookup may be issued in every cycle.

Top module: `lpm_cam`

## Requirements
- R1: While `rst_n` is low and after it is released, every entry is invalid and `res_valid` is 0. Until an entry has been written, every lookup returns `res_found`=0.
- R2: The match length of a valid entry is the number of leading bits, counted from bit 31 downward, where the key equals the stored address. It stops at the first differing bit and never exceeds the entry's prefix length.
- R3: A prefix length written above 32 is stored as 32.
- R4: An entry counts as a candidate only when it is valid and its match length is nonzero. When no entry is a candidate, the result is `res_found`=0, `res_idx`=0 and `res_len`=0. When `res_found`=1, `res_len` is nonzero.
- R5: The result is the candidate with the greatest match length, whatever its position in the table.
- R6: When two or more candidates share the greatest match length, the one with the lowest index wins.
- R7: The result of a lookup issued with `lk_en`=1 appears 1+log2(NUM_ENTRIES) cycles later (4 cycles for 8 entries). `res_valid` is 1 in exactly that cycle and is `lk_en` delayed by the same amount.
- R8: Lookups may be issued in consecutive cycles. Each one produces its own correct result, in order.
- R9: A write at a rising edge is seen by lookups issued from the next cycle onward. A lookup issued in the same cycle as the write sees the old contents.
- R10: Writing an entry with `wr_valid`=0 removes it from all later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Load one entry this cycle |
| wr_idx | input | 3 | Entry index to load |
| wr_addr | input | 32 | Address to store |
| wr_plen | input | 6 | Prefix length, 0 to 63 (values above 32 are clamped) |
| wr_valid | input | 1 | Valid bit to store |
| lk_en | input | 1 | Issue a lookup this cycle |
| lk_addr | input | 32 | Lookup key |
| res_valid | output | 1 | Result present this cycle |
| res_found | output | 1 | At least one candidate matched |
| res_idx | output | 3 | Index of the winning entry |
| res_len | output | 6 | Match length of the winning entry |

## Verification
A corrupt stored prefix length or address changes `res_len` or `res_idx` for the lookup that touches that entry. The error shows at the ports exactly four cycles after that lookup is issued. A wrong node decision in the tree returns a shorter or higher-index winner in the same cycle. A slip in the valid pipeline makes `res_valid` disagree with the delayed `lk_en` on the very first lookup. The bench mixes seeded random writes and keys, with keys built close to stored addresses, with directed ties, reordering, clamping, removal and same-cycle write/lookup cases.

// File: rtl/lpm_cam_pkg.sv
package lpm_cam_pkg;

    localparam int LPM_ADDR_W  = 32;
    localparam int LPM_GROUP_W = 8;
    localparam int LPM_ENTRIES = 8;

    // decision taken by one selection node
    typedef enum logic {
        TAKE_LEFT  = 1'b0,
        TAKE_RIGHT = 1'b1
    } pick_e;

    // right side wins only with a strictly longer real match
    function automatic pick_e choose(input logic l_hit, input logic [7:0] l_len,
                                     input logic r_hit, input logic [7:0] r_len);
        if (r_hit && (!l_hit || (r_len > l_len)))
            return TAKE_RIGHT;
        return TAKE_LEFT;
    endfunction

endpackage

// File: rtl/lpm_table.sv
module lpm_table #(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int LEN_W      = $clog2(ADDR_W + 1)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [IDX_W-1:0]                      wr_idx,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [LEN_W-1:0]                      wr_plen,
    input  logic                                  wr_valid,
    output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]    ent_addr,
    output logic [NUM_ENTRIES-1:0][LEN_W-1:0]     ent_plen,
    output logic [NUM_ENTRIES-1:0]                ent_valid
);

    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(ADDR_W);

    logic [LEN_W-1:0] plen_clamped;

    always_comb begin
        plen_clamped = (wr_plen > MAX_LEN) ? MAX_LEN : wr_plen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_addr  <= '0;
            ent_plen  <= '0;
            ent_valid <= '0;
        end else if (wr_en) begin
            ent_addr[wr_idx]  <= wr_addr;
            ent_plen[wr_idx]  <= plen_clamped;
            ent_valid[wr_idx] <= wr_valid;
        end
    end

endmodule

// File: rtl/lpm_match.sv
module lpm_match #(
    parameter int ADDR_W  = 32,
    parameter int GROUP_W = 8,
    localparam int LEN_W  = $clog2(ADDR_W + 1),
    localparam int NUM_GRP = ADDR_W / GROUP_W
) (
    input  logic              ent_valid,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [LEN_W-1:0]  ent_plen,
    input  logic [ADDR_W-1:0] key,
    output logic              cand,
    output logic [LEN_W-1:0]  match_len
);

    logic [ADDR_W-1:0]  mask;
    logic [ADDR_W-1:0]  diff;
    logic [NUM_GRP-1:0] grp_eq;

    // contiguous mask grown from the top bit down to the prefix length
    always_comb begin
        for (int b = 0; b < ADDR_W; b++) begin
            mask[ADDR_W-1-b] = (b < int'(ent_plen));
        end
        diff = (ent_addr ^ key) & mask;
    end

    // one equality flag per byte-wide group, group 0 at the top
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp_eq[g] = ~|diff[ADDR_W-1-g*GROUP_W -: GROUP_W];
    end

    always_comb begin
        int   raw;
        int   capped;
        logic run;
        raw = 0;
        run = 1'b1;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (run) begin
                if (grp_eq[g]) begin
                    raw = raw + GROUP_W;
                end else begin
                    for (int b = 0; b < GROUP_W; b++) begin
                        if (run) begin
                            if (diff[ADDR_W-1-g*GROUP_W-b]) run = 1'b0;
                            else                             raw = raw + 1;
                        end
                    end
                    run = 1'b0;
                end
            end
        end
        capped    = (raw < int'(ent_plen)) ? raw : int'(ent_plen);
        match_len = LEN_W'(capped);
        cand      = ent_valid && (capped != 0);
    end

endmodule

// File: rtl/lpm_tree.sv
module lpm_tree
    import lpm_cam_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int LEN_W      = $clog2(ADDR_W + 1),
    localparam int LAT        = 1 + $clog2(NUM_ENTRIES),
    localparam int NODES      = 2 * NUM_ENTRIES - 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              lk_en,
    input  logic [NUM_ENTRIES-1:0]            leaf_cand,
    input  logic [NUM_ENTRIES-1:0][LEN_W-1:0] leaf_len,
    output logic                              res_valid,
    output logic                              res_found,
    output logic [IDX_W-1:0]                  res_idx,
    output logic [LEN_W-1:0]                  res_len
);

    // heap layout: node k has children 2k+1 and 2k+2, leaves at NUM_ENTRIES-1 upward
    logic [NODES-1:0]            nd_hit;
    logic [NODES-1:0][IDX_W-1:0] nd_idx;
    logic [NODES-1:0][LEN_W-1:0] nd_len;
    logic [LAT-1:0]              vld_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nd_hit <= '0;
            nd_idx <= '0;
            nd_len <= '0;
        end else begin
            for (int k = 0; k < NUM_ENTRIES - 1; k++) begin
                unique case (choose(nd_hit[2*k+1], 8'(nd_len[2*k+1]),
                                    nd_hit[2*k+2], 8'(nd_len[2*k+2])))
                    TAKE_RIGHT: begin
                        nd_hit[k] <= nd_hit[2*k+2];
                        nd_idx[k] <= nd_idx[2*k+2];
                        nd_len[k] <= nd_len[2*k+2];
                    end
                    TAKE_LEFT: begin
                        nd_hit[k] <= nd_hit[2*k+1];
                        nd_idx[k] <= nd_idx[2*k+1];
                        nd_len[k] <= nd_len[2*k+1];
                    end
                endcase
            end
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                nd_hit[NUM_ENTRIES-1+i] <= leaf_cand[i];
                nd_idx[NUM_ENTRIES-1+i] <= leaf_cand[i] ? IDX_W'(i) : '0;
                nd_len[NUM_ENTRIES-1+i] <= leaf_cand[i] ? leaf_len[i] : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= {vld_pipe[LAT-2:0], lk_en};
    end

    always_comb begin
        res_valid = vld_pipe[LAT-1];
        res_found = nd_hit[0];
        res_idx   = nd_idx[0];
        res_len   = nd_len[0];
    end

endmodule

// File: rtl/lpm_cam.sv
module lpm_cam #(
    parameter int NUM_ENTRIES = lpm_cam_pkg::LPM_ENTRIES,
    parameter int ADDR_W      = lpm_cam_pkg::LPM_ADDR_W,
    parameter int GROUP_W     = lpm_cam_pkg::LPM_GROUP_W,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int LEN_W      = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_plen,
    input  logic              wr_valid,
    input  logic              lk_en,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_found,
    output logic [IDX_W-1:0]  res_idx,
    output logic [LEN_W-1:0]  res_len
);

    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic [NUM_ENTRIES-1:0][LEN_W-1:0]  ent_plen;
    logic [NUM_ENTRIES-1:0]             ent_valid;
    logic [NUM_ENTRIES-1:0]             cand;
    logic [NUM_ENTRIES-1:0][LEN_W-1:0]  mlen;

    lpm_table #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .ADDR_W     (ADDR_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_addr  (wr_addr),
        .wr_plen  (wr_plen),
        .wr_valid (wr_valid),
        .ent_addr (ent_addr),
        .ent_plen (ent_plen),
        .ent_valid(ent_valid)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        lpm_match #(
            .ADDR_W (ADDR_W),
            .GROUP_W(GROUP_W)
        ) u_match (
            .ent_valid(ent_valid[e]),
            .ent_addr (ent_addr[e]),
            .ent_plen (ent_plen[e]),
            .key      (lk_addr),
            .cand     (cand[e]),
            .match_len(mlen[e])
        );
    end

    lpm_tree #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .ADDR_W     (ADDR_W)
    ) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_en    (lk_en),
        .leaf_cand(cand),
        .leaf_len (mlen),
        .res_valid(res_valid),
        .res_found(res_found),
        .res_idx  (res_idx),
        .res_len  (res_len)
    );

endmodule

// File: rtl/lpm_cam_chk.sv
module lpm_cam_chk #(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int LEN_W      = $clog2(ADDR_W + 1),
    localparam int LAT        = 1 + $clog2(NUM_ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_en,
    input logic             res_valid,
    input logic             res_found,
    input logic [IDX_W-1:0] res_idx,
    input logic [LEN_W-1:0] res_len
);

    logic [LAT-1:0] shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow <= '0;
        else        shadow <= {shadow[LAT-2:0], lk_en};
    end

    // R7
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == shadow[LAT-1]);

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_found |-> (res_len == '0 && res_idx == '0));

    // R4
    hit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_found |-> (res_len != '0));

    // R3
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_len <= LEN_W'(ADDR_W));

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !res_valid);

endmodule

bind lpm_cam lpm_cam_chk #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_en    (lk_en),
    .res_valid(res_valid),
    .res_found(res_found),
    .res_idx  (res_idx),
    .res_len  (res_len)
);

// File: tb/lpm_cam_test.sv
module lpm_cam_test;

    localparam int N   = 8;
    localparam int AW  = 32;
    localparam int IW  = 3;
    localparam int LW  = 6;
    localparam int LAT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [LW-1:0] wr_plen = '0;
    logic          wr_valid = 1'b0;
    logic          lk_en = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          res_valid;
    logic          res_found;
    logic [IW-1:0] res_idx;
    logic [LW-1:0] res_len;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench-side table model
    logic [AW-1:0] m_addr [N];
    int            m_plen [N];
    bit            m_valid[N];

    // expectation pipeline
    bit    q_v[LAT];
    bit    q_f[LAT];
    int    q_i[LAT];
    int    q_l[LAT];
    string q_t[LAT];

    always #10 clk = ~clk;

    lpm_cam uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr),
        .wr_plen(wr_plen), .wr_valid(wr_valid),
        .lk_en(lk_en), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_found(res_found),
        .res_idx(res_idx), .res_len(res_len)
    );

    function automatic int lead_len(input logic [AW-1:0] a, input logic [AW-1:0] k, input int p);
        int n = 0;
        for (int i = 0; i < p; i++) begin
            if (a[AW-1-i] != k[AW-1-i]) break;
            n++;
        end
        return n;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one cycle: check result due now, then drive the next inputs
    task automatic step(input bit we, input int wi, input logic [AW-1:0] wa, input int wp,
                        input bit wv, input bit le, input logic [AW-1:0] la, input string tag);
        int best;
        int bidx;
        @(negedge clk);
        chk("R7", "res_valid", int'(res_valid), int'(q_v[LAT-1]));
        if (q_v[LAT-1]) begin
            chk(q_t[LAT-1], "found", int'(res_found), int'(q_f[LAT-1]));
            chk(q_t[LAT-1], "idx",   int'(res_idx),   q_i[LAT-1]);
            chk(q_t[LAT-1], "len",   int'(res_len),   q_l[LAT-1]);
        end
        for (int s = LAT - 1; s > 0; s--) begin
            q_v[s] = q_v[s-1]; q_f[s] = q_f[s-1];
            q_i[s] = q_i[s-1]; q_l[s] = q_l[s-1]; q_t[s] = q_t[s-1];
        end
        best = 0;
        bidx = 0;
        for (int e = 0; e < N; e++) begin
            int l;
            l = m_valid[e] ? lead_len(m_addr[e], la, m_plen[e]) : 0;
            if (l > best) begin best = l; bidx = e; end
        end
        q_v[0] = le; q_f[0] = (best > 0); q_i[0] = bidx; q_l[0] = best; q_t[0] = tag;
        wr_en = we; wr_idx = IW'(wi); wr_addr = wa; wr_plen = LW'(wp); wr_valid = wv;
        lk_en = le; lk_addr = la;
        if (we) begin
            m_addr[wi]  = wa;
            m_plen[wi]  = (wp > AW) ? AW : wp;
            m_valid[wi] = wv;
        end
    endtask

    task automatic look(input logic [AW-1:0] la, input string tag);
        step(1'b0, 0, '0, 0, 1'b0, 1'b1, la, tag);
    endtask

    task automatic load(input int wi, input logic [AW-1:0] wa, input int wp, input bit wv);
        step(1'b1, wi, wa, wp, wv, 1'b0, '0, "R9");
    endtask

    initial begin
        void'($urandom(32'd7321));
        for (int e = 0; e < N; e++) begin
            m_addr[e] = '0; m_plen[e] = 0; m_valid[e] = 1'b0;
        end
        for (int s = 0; s < LAT; s++) begin
            q_v[s] = 1'b0; q_f[s] = 1'b0; q_i[s] = 0; q_l[s] = 0; q_t[s] = "R7";
        end
        repeat (3) @(negedge clk);
        chk("R1", "res_valid in reset", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "res_valid after reset", int'(res_valid), 0);
        chk("R1", "res_found after reset", int'(res_found), 0);

        // R1 empty table
        look(32'hC0A80105, "R1");
        // R9 write and lookup in the same cycle: old contents
        step(1'b1, 5, 32'hC0A80100, 24, 1'b1, 1'b1, 32'hC0A80105, "R9");
        look(32'hC0A80105, "R9");
        // R6 tie: idx 2 beats idx 5
        load(2, 32'hC0A80100, 24, 1'b1);
        look(32'hC0A80105, "R6");
        // R5 longer match at a higher index wins
        load(7, 32'hC0A80104, 30, 1'b1);
        look(32'hC0A80105, "R5");
        // R3 prefix length 40 clamped to 32
        load(1, 32'hC0A80105, 40, 1'b1);
        look(32'hC0A80105, "R3");
        // R10 removal
        load(1, 32'hC0A80105, 32, 1'b0);
        look(32'hC0A80105, "R10");
        // R4 first bit differs everywhere
        look(32'h00000000, "R4");
        // R2 partial match stops at the first differing bit
        look(32'hC0A8FF00, "R2");
        look(32'hC0A80180, "R2");
        // R8 back-to-back different keys
        look(32'hC0A80104, "R8");
        look(32'hC0A80107, "R8");
        look(32'h40000000, "R8");

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            bit            we;
            int            wi;
            int            wp;
            logic [AW-1:0] wa;
            logic [AW-1:0] key;
            int            r;
            we = ($urandom_range(0, 3) == 0);
            wi = $urandom_range(0, N - 1);
            wp = $urandom_range(0, 40);
            wa = {8'hC0, 8'($urandom_range(0, 3)), $urandom_range(0, 65535)};
            r  = $urandom_range(0, N - 1);
            key = m_addr[r] ^ (32'h1 << $urandom_range(0, 31));
            if ($urandom_range(0, 7) == 0) key = $urandom;
            step(we, wi, wa, wp, ($urandom_range(0, 7) != 0),
                 ($urandom_range(0, 4) != 0), key, "R5");
        end
        for (int f = 0; f < LAT + 1; f++) step(1'b0, 0, '0, 0, 1'b0, 1'b0, '0, "R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule